// File: doc/BRIEF.md
# Rational Fractional Clock-Enable Generator

This block runs on one fast system clock and emits a single-cycle enable pulse whose long-run rate is exactly step/modulus times the clock rate. The default setting is step 66 and modulus 980. At a 140 MHz clock this gives 66/7 MHz, about 9.43 MHz, with 14.85 clocks per pulse on average. A phase register gains the step every cycle. When the sum reaches the modulus, the modulus is subtracted and a pulse is raised. Because the wrap is at an arbitrary integer and not at a power of two, the count of pulses over any whole number of modulus periods is exact. There is no slow drift.

With each pulse the block also gives a half-cycle marker. It is high when the phase left over after the wrap is below half the step. This means the ideal crossing lay less than half a clock before the edge that raised the pulse. A downstream double-data-rate output stage can use it to place the edge on the correct half of the clock, which cuts the timing jitter from one period to half a period.

A new step and modulus can be loaded while the block runs. A valid load is held back until the next wrap, so the pulse stream never gets an extra or a short pulse. An invalid load drives the block into a sticky fault state that stops all pulses until the next reset. Control is a three-state machine:
- ST_RUN: normal running.
  - A valid load goes to ST_ARMED.
  - An invalid load goes to ST_FAULT.
- ST_ARMED: a new setting is waiting for the next wrap.
  - The wrap applies it and returns to ST_RUN.
  - A further valid load replaces the waiting setting and stays in ST_ARMED.
  - An invalid load goes to ST_FAULT.
- ST_FAULT: stays in ST_FAULT until reset.

Top module: `ratio_tick_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `tick_o`, `late_half_o` and `fault_o` are 0, and the phase is zero. With the default step 66 and modulus 980, the first tick is seen after the 15th rising edge following reset release, and none is seen after the 14th.
- R2: Starting from zero phase at step N and modulus D, exactly N*k ticks occur in any run of D*k consecutive edges, and the internal phase always stays below the active modulus.
- R3: The spacing between successive ticks is always floor(D/N) or ceil(D/N) edges. This is 14 or 15 for the defaults, and 1 or 2 for step 10 and modulus 11.
- R4: Tick j after a zero-phase start is raised by edge ceil(j*D/N) counted from that start, and `tick_o` is high for that one cycle only.
- R5: `late_half_o` is high only together with `tick_o`. It is high exactly when 2*(m*N - j*D) < N for tick j at edge m.
- R6: A `cfg_load` is valid when `cfg_step` is nonzero and less than `cfg_mod` (both unsigned). A valid load, sampled at edge L, changes nothing until the first tick after L. That tick keeps its old timing, and the phase then restarts from zero at the new step and modulus.
- R7: A load with step 0, or with step not less than modulus, sets `fault_o` from the next cycle on. From the edge after that, no tick or half flag appears. Any later load, valid or not, leaves the fault set until reset.
- R8: A reset taken from the fault state clears `fault_o` and restores the default step and modulus.
- R9: A valid load made while an earlier setting is still waiting replaces that setting. Only the latest one is applied at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | One-cycle strobe that offers a new step and modulus |
| cfg_step | input | W | Phase increment per clock (numerator) |
| cfg_mod | input | W | Wrap modulus (denominator) |
| tick_o | output | 1 | One-cycle enable pulse at the fractional rate |
| late_half_o | output | 1 | With a tick: ideal crossing lay less than half a clock before this edge |
| fault_o | output | 1 | Sticky flag for an invalid setting |

## Verification
The main function is driven with four ratios.
- The default 66/980 over three full periods checks both the exact long-run count and the 14/15 spacing.
- 7/20 with spacings of 2 and 3 tells apart a correct restart at the wrap from one that keeps the old phase.
- 5/11, loaded on top of a waiting 3/10, shows whether the latest pending setting wins.
- 10/11 forces back-to-back ticks and checks that the spacing law still holds at its narrowest.

A scoreboard predicts the edge and half flag of each tick from the ceil(j*D/N) formula, so any missed, extra or shifted tick and any wrong half flag is caught. Step 0 and step equal to modulus check both fault conditions, their stickiness, and the return to the defaults after reset.

// File: rtl/ratio_tick_pkg.sv
package ratio_tick_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FAULT = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/ratio_cfg_check.sv
module ratio_cfg_check #(
    parameter int W = 12
) (
    input  logic [W-1:0] step,
    input  logic [W-1:0] modv,
    output logic         ok
);

    // A usable ratio needs a nonzero step strictly below the modulus.
    always_comb begin
        ok = (step != '0) && (step < modv);
    end

endmodule

// File: rtl/ratio_phase_acc.sv
module ratio_phase_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         restart,
    input  logic [W-1:0] step,
    input  logic [W-1:0] modv,
    output logic         wrap,
    output logic [W-1:0] phase,
    output logic         tick_o,
    output logic         late_half_o
);

    localparam int SW = W + 1;

    logic [SW-1:0] sum;
    logic [W-1:0]  rem;
    logic          late_c;

    always_comb begin
        sum    = {1'b0, phase} + {1'b0, step};
        wrap   = (sum >= {1'b0, modv});
        // sum - modv is below the step, so it fits in W bits on a wrap.
        rem    = sum[W-1:0] - modv;
        late_c = ({rem, 1'b0} < {1'b0, step});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= '0;
            tick_o      <= 1'b0;
            late_half_o <= 1'b0;
        end else begin
            tick_o      <= advance && wrap;
            late_half_o <= advance && wrap && late_c;
            if (advance) begin
                if (wrap) begin
                    phase <= restart ? '0 : rem;
                end else begin
                    phase <= sum[W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
    import ratio_tick_pkg::*;
#(
    parameter int W        = 12,
    parameter int DEF_STEP = 66,
    parameter int DEF_MOD  = 980
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         load_ok,
    input  logic [W-1:0] load_step,
    input  logic [W-1:0] load_mod,
    input  logic         wrap,
    output logic [W-1:0] act_step,
    output logic [W-1:0] act_mod,
    output logic         advance,
    output logic         restart,
    output logic         fault
);

    localparam logic         DEF_OK   = (DEF_STEP > 0) && (DEF_STEP < DEF_MOD);
    localparam logic [W-1:0] DEF_S    = W'(DEF_STEP);
    localparam logic [W-1:0] DEF_M    = W'(DEF_MOD);
    localparam ctrl_state_e  ST_START = DEF_OK ? ST_RUN : ST_FAULT;

    ctrl_state_e  state;
    ctrl_state_e  state_nxt;
    logic [W-1:0] pend_step;
    logic [W-1:0] pend_mod;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decision.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (load && !load_ok)      state_nxt = ST_FAULT;
                else if (load)             state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (load && !load_ok)      state_nxt = ST_FAULT;
                else if (load)             state_nxt = ST_ARMED;
                else if (wrap)             state_nxt = ST_RUN;
            end
            ST_FAULT: begin
                state_nxt = ST_FAULT;
            end
            default: begin
                state_nxt = ST_FAULT;
            end
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        advance = 1'b0;
        restart = 1'b0;
        fault   = 1'b0;
        unique case (state)
            ST_RUN: begin
                advance = 1'b1;
            end
            ST_ARMED: begin
                advance = 1'b1;
                restart = wrap;
            end
            ST_FAULT: begin
                fault = 1'b1;
            end
            default: begin
                fault = 1'b1;
            end
        endcase
    end

    // Waiting and active ratio registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_step <= DEF_S;
            pend_mod  <= DEF_M;
            act_step  <= DEF_S;
            act_mod   <= DEF_M;
        end else begin
            if (load && load_ok && (state != ST_FAULT)) begin
                pend_step <= load_step;
                pend_mod  <= load_mod;
            end
            if ((state == ST_ARMED) && wrap) begin
                act_step <= pend_step;
                act_mod  <= pend_mod;
            end
        end
    end

endmodule

// File: rtl/ratio_tick_gen.sv
module ratio_tick_gen #(
    parameter int W        = 12,
    parameter int DEF_STEP = 66,
    parameter int DEF_MOD  = 980
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_step,
    input  logic [W-1:0] cfg_mod,
    output logic         tick_o,
    output logic         late_half_o,
    output logic         fault_o
);

    logic         cfg_ok_w;
    logic         wrap_w;
    logic         advance_w;
    logic         restart_w;
    logic [W-1:0] act_step_w;
    logic [W-1:0] act_mod_w;
    logic [W-1:0] phase_w;

    ratio_cfg_check #(.W(W)) u_check (
        .step (cfg_step),
        .modv (cfg_mod),
        .ok   (cfg_ok_w)
    );

    ratio_ctrl #(
        .W        (W),
        .DEF_STEP (DEF_STEP),
        .DEF_MOD  (DEF_MOD)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .load_ok   (cfg_ok_w),
        .load_step (cfg_step),
        .load_mod  (cfg_mod),
        .wrap      (wrap_w),
        .act_step  (act_step_w),
        .act_mod   (act_mod_w),
        .advance   (advance_w),
        .restart   (restart_w),
        .fault     (fault_o)
    );

    ratio_phase_acc #(.W(W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance_w),
        .restart     (restart_w),
        .step        (act_step_w),
        .modv        (act_mod_w),
        .wrap        (wrap_w),
        .phase       (phase_w),
        .tick_o      (tick_o),
        .late_half_o (late_half_o)
    );

endmodule

// File: rtl/ratio_tick_chk.sv
module ratio_tick_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_o,
    input logic         late_half_o,
    input logic         fault_o,
    input logic [W-1:0] phase,
    input logic [W-1:0] act_mod
);

    AST_HALF_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        late_half_o |-> tick_o); // R5

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o); // R7

    AST_SILENT_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> (!tick_o && !late_half_o)); // R7

    AST_PHASE_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
        phase < act_mod); // R2

endmodule

bind ratio_tick_gen ratio_tick_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_o      (tick_o),
    .late_half_o (late_half_o),
    .fault_o     (fault_o),
    .phase       (phase_w),
    .act_mod     (act_mod_w)
);

// File: tb/ratio_tick_gen_test.sv
module ratio_tick_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_load = 1'b0;
    logic [W-1:0] cfg_step = '0;
    logic [W-1:0] cfg_mod  = '0;
    logic         tick_o;
    logic         late_half_o;
    logic         fault_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ratio_tick_gen #(.W(W)) uut (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .cfg_step    (cfg_step),
        .cfg_mod     (cfg_mod),
        .tick_o      (tick_o),
        .late_half_o (late_half_o),
        .fault_o     (fault_o)
    );

    typedef struct packed {
        logic [31:0] cyc;
        logic        late;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        mon_e;
    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_req = "R4";
    int unsigned edge_no = 0;
    int unsigned tick_cnt = 0;
    int unsigned last_tick = 0;
    int unsigned gap_min = 32'hFFFF;
    int unsigned gap_max = 0;

    always @(posedge clk) begin
        if (rst) edge_no <= 0;
        else     edge_no <= edge_no + 1;
    end

    task automatic note(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard at each falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            while (sb_q.size() > 0 && sb_q[0].cyc < edge_no) begin
                note(1'b0, cur_req, "missed tick at edge", edge_no, sb_q[0].cyc);
                void'(sb_q.pop_front());
            end
            if (tick_o) begin
                tick_cnt++;
                if (last_tick != 0) begin
                    if (edge_no - last_tick < gap_min) gap_min = edge_no - last_tick;
                    if (edge_no - last_tick > gap_max) gap_max = edge_no - last_tick;
                end
                last_tick = edge_no;
                if (sb_q.size() == 0) begin
                    note(1'b0, cur_req, "unexpected tick at edge", edge_no, 0);
                end else begin
                    mon_e = sb_q.pop_front();
                    note(mon_e.cyc == edge_no, cur_req, "R4 tick edge", edge_no, mon_e.cyc);
                    note(late_half_o == mon_e.late, "R5", "half flag", late_half_o, mon_e.late);
                end
            end else if (late_half_o) begin
                note(1'b0, "R5", "half flag without tick", 1, 0);
            end
        end
    end

    // Driver side: predicted ticks from the ceil(j*D/N) law.
    task automatic push_sched(input int unsigned base, input int unsigned n,
                              input int unsigned d, input int unsigned count);
        for (int unsigned j = 1; j <= count; j++) begin
            int unsigned m;
            exp_t        e;
            m      = (j * d + n - 1) / n;
            e.cyc  = base + m;
            e.late = (2 * (m * n - j * d)) < n;
            sb_q.push_back(e);
        end
    endtask

    task automatic step_to_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_to(input int unsigned target);
        while (edge_no < target) step_to_neg();
    endtask

    task automatic do_reset();
        step_to_neg();
        rst      = 1'b1;
        cfg_load = 1'b0;
        sb_q.delete();
        step_to_neg();
        step_to_neg();
        note(tick_o == 1'b0, "R1", "tick in reset", tick_o, 0);
        note(late_half_o == 1'b0, "R1", "half flag in reset", late_half_o, 0);
        note(fault_o == 1'b0, "R1", "fault in reset", fault_o, 0);
        tick_cnt  = 0;
        last_tick = 0;
        gap_min   = 32'hFFFF;
        gap_max   = 0;
        push_sched(0, 66, 980, 300);
        rst = 1'b0;
    endtask

    task automatic apply_load(input int unsigned n, input int unsigned d, input bit valid,
                              output int unsigned e_edge, output int unsigned l_edge);
        int idx;
        step_to_neg();
        l_edge   = edge_no + 1;
        cfg_load = 1'b1;
        cfg_step = W'(n);
        cfg_mod  = W'(d);
        step_to_neg();
        cfg_load = 1'b0;
        e_edge   = 0;
        if (valid) begin
            idx = -1;
            for (int i = 0; i < sb_q.size(); i++) begin
                if (idx < 0 && sb_q[i].cyc > l_edge) idx = i;
            end
            if (idx < 0) begin
                note(1'b0, "R6", "no wrap left in schedule", 0, 1);
            end else begin
                e_edge = sb_q[idx].cyc;
                while (sb_q.size() > idx + 1) void'(sb_q.pop_back());
                push_sched(e_edge, n, d, 200);
            end
        end else begin
            while (sb_q.size() > 0 && sb_q[sb_q.size()-1].cyc > l_edge) void'(sb_q.pop_back());
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned e1, e2, l1, c0;

        // R1 and R2/R3 with the default 66/980 ratio
        cur_req = "R1";
        do_reset();
        wait_to(14);
        note(tick_o == 1'b0, "R1", "tick at edge 14", tick_o, 0);
        wait_to(15);
        note(tick_o == 1'b1, "R1", "tick at edge 15", tick_o, 1);
        cur_req = "R2";
        wait_to(2940);
        note(tick_cnt == 198, "R2", "ticks in 3*980 edges", tick_cnt, 198);
        note(gap_min == 14, "R3", "shortest spacing", gap_min, 14);
        note(gap_max == 15, "R3", "longest spacing", gap_max, 15);

        // R6: deferred load of 7/20 with phase restart
        cur_req = "R6";
        apply_load(7, 20, 1'b1, e1, l1);
        wait_to(e1 + 1);
        c0 = tick_cnt;
        note(fault_o == 1'b0, "R6", "fault after valid load", fault_o, 0);
        wait_to(e1 + 2);
        note(tick_o == 1'b0, "R6", "no tick two after wrap", tick_o, 0);
        wait_to(e1 + 3);
        note(tick_o == 1'b1, "R6", "first new-rate tick", tick_o, 1);
        wait_to(e1 + 60);
        note(tick_cnt - c0 == 21, "R6", "ticks in 3*20 edges", tick_cnt - c0, 21);

        // R9: second pending load replaces the first
        cur_req = "R1";
        do_reset();
        wait_to(16);
        cur_req = "R9";
        apply_load(3, 10, 1'b1, e1, l1);
        apply_load(5, 11, 1'b1, e2, l1);
        note(e2 == 30, "R9", "wrap edge for pending swap", e2, 30);
        wait_to(e2 + 1);
        c0 = tick_cnt;
        wait_to(e2 + 44);
        note(tick_cnt - c0 == 20, "R9", "ticks in 4*11 edges", tick_cnt - c0, 20);

        // R3: back-to-back ticks at 10/11
        cur_req = "R3";
        apply_load(10, 11, 1'b1, e1, l1);
        wait_to(e1 + 1);
        c0        = tick_cnt;
        last_tick = 0;
        gap_min   = 32'hFFFF;
        gap_max   = 0;
        wait_to(e1 + 110);
        note(gap_min == 1, "R3", "shortest spacing 10/11", gap_min, 1);
        note(gap_max == 2, "R3", "longest spacing 10/11", gap_max, 2);
        note(tick_cnt - c0 == 100, "R2", "ticks in 10*11 edges", tick_cnt - c0, 100);

        // R7: zero step faults, sticky against a later valid load
        cur_req = "R7";
        apply_load(0, 11, 1'b0, e1, l1);
        note(fault_o == 1'b1, "R7", "fault after zero step", fault_o, 1);
        c0 = tick_cnt;
        wait_to(l1 + 100);
        note(tick_cnt == c0, "R7", "ticks during fault", tick_cnt, c0);
        apply_load(5, 11, 1'b0, e1, l1);
        wait_to(l1 + 50);
        note(fault_o == 1'b1, "R7", "fault after later valid load", fault_o, 1);
        note(tick_cnt == c0, "R7", "ticks after later load", tick_cnt, c0);

        // R8: reset leaves fault and restores defaults
        cur_req = "R8";
        do_reset();
        wait_to(15);
        note(tick_o == 1'b1, "R8", "default first tick after fault reset", tick_o, 1);
        note(fault_o == 1'b0, "R8", "fault cleared by reset", fault_o, 0);

        // R7: step equal to modulus
        cur_req = "R7";
        apply_load(20, 20, 1'b0, e1, l1);
        note(fault_o == 1'b1, "R7", "fault for step equal modulus", fault_o, 1);
        c0 = tick_cnt;
        wait_to(l1 + 40);
        note(tick_cnt == c0, "R7", "ticks after step==modulus", tick_cnt, c0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule